// File: doc/BRIEF.md
# Multiplexed ADC Read Sequencer

This controller reads one channel of an external 16-input, 8-bit converter. The converter shares a single 8-bit bidirectional port for the channel select and the result. A separate control line latches the channel and starts the conversion. A request carrying a channel number is taken over a valid/ready handshake. The block then runs a timed sequence:

1. It turns the port to output and drives the channel number with the fast-clock bit held low.
2. It raises the control line to capture the channel and reset the converter.
3. It lowers the control line to start the conversion.
4. It turns the port around and samples the result.

The result comes back with a one-cycle done strobe. The three waits are parameters and are counted by one shared down-counter.

A machine-type input tells the block which channels exist on the attached machine. On the newer, two-port machine type, a request for a channel that is not wired there is rejected at once with an error flag. A rejected request never touches the port or the control line.

The request side follows a valid/ready rule. A request transfers only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of a running sequence, and a requester that sees it low must hold its request until it rises. The result side has no back-pressure. `done`, `err` and `result` are a strobe that the consumer must take in the cycle it appears.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, `port_oe`, `latch_ctl`, `busy` and `done` are 0, `req_ready` is 1 and `result` is 0.
- R2: In the cycle after an allowed request is accepted, and for `T_SETUP` cycles in all, the outputs are held as follows. `port_oe` is 1. `port_out[3:0]` carries the channel number. `port_out[7]` (the fast-clock select) is 0, as are the other upper bits. `latch_ctl` is 0.
- R3: Directly after the setup window, `latch_ctl` is 1 for exactly `T_LATCH` cycles while the port keeps driving the channel.
- R4: After the latch window, `latch_ctl` is 0 for `T_CONV` cycles while `port_oe` stays 1.
- R5: After the conversion window, `port_oe` is 0 for one full cycle. In the next cycle `done` pulses for one cycle with `err` = 0, and `result` equals the value `port_in` held at the end of that cycle with the port released.
- R6: When `mach_old` = 0, channels 4, 5, 9, 10, 12, 13 and 14 are rejected. In the cycle after acceptance, `done` and `err` are 1, `port_oe` and `latch_ctl` never rise, and `result` keeps its previous value.
- R7: When `mach_old` = 1, every channel 0 to 15 runs the full sequence.
- R8: `busy` is 1 and `req_ready` is 0 from the cycle after an allowed request is accepted until the cycle `done` rises. Requests offered in that time are ignored: the driven channel does not change and no second sequence follows.
- R9: `result` changes only in a cycle where `done` = 1 and `err` = 0, and otherwise holds its last value.
- R10: With `req_valid` = 0 the block stays idle, whatever `req_chan` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_chan | input | 4 | Channel to read |
| mach_old | input | 1 | 1: older four-port machine, all channels; 0: two-port machine |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | With `done`: request rejected |
| result | output | 8 | Last converted value |
| port_out | output | 8 | Shared port drive value |
| port_oe | output | 1 | Shared port output enable |
| port_in | input | 8 | Shared port read value |
| latch_ctl | output | 1 | Latch/reset (high) and start (low edge) control |

## Verification
Reads are run on channels 0, 3, 12 and 15, on both machine types and with distinct converter values. This separates a correct channel field from a stuck or shifted one, and a correct machine check from one that ignores `mach_old`. Each read is followed cycle by cycle through the setup, latch, conversion and release windows, so a window that is one cycle long or short shows up. Each channel from the rejected set is offered on the two-port machine to catch a wrong mask. Requests are also offered during a sequence and held with `req_valid` low, and the result is read after a rejection, to show what must not change.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LATCH,
    ST_CONV,
    ST_GAP
  } seq_state_t;

  // Channels wired on the two-port machine: all but 4,5,9,10,12,13,14.
  localparam logic [15:0] NEW_MACH_OK = 16'h89CF;
endpackage

// File: rtl/adc_chan_gate.sv
module adc_chan_gate #(
  parameter int CHAN_W = 4,
  parameter logic [(1<<CHAN_W)-1:0] NEW_OK = '1
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic              mach_old,
  output logic              allowed
);
  always_comb allowed = mach_old | NEW_OK[chan];
endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // Counter rests at zero and never wraps below it (supports R3/R4 windows).
  p_cnt_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHAN_W  = 4,
  parameter int T_SETUP = 1280,
  parameter int T_LATCH = 1280,
  parameter int T_CONV  = 2560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              mach_old,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] port_out,
  output logic              port_oe,
  input  logic [DATA_W-1:0] port_in,
  output logic              latch_ctl
);
  localparam int T_MAX1 = (T_SETUP > T_LATCH) ? T_SETUP : T_LATCH;
  localparam int T_MAX  = (T_MAX1 > T_CONV) ? T_MAX1 : T_CONV;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  seq_state_t        state;
  logic [CHAN_W-1:0] chan_q;
  logic              allowed, accept, expired, load;
  logic [CNT_W-1:0]  load_val;

  adc_chan_gate #(.CHAN_W(CHAN_W), .NEW_OK(NEW_MACH_OK)) gate_i (
    .chan(req_chan), .mach_old(mach_old), .allowed(allowed));

  adc_wait_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .expired(expired));

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign port_oe   = (state == ST_SETUP) || (state == ST_LATCH) || (state == ST_CONV);
  assign latch_ctl = (state == ST_LATCH);
  // Upper bits, including the fast-clock select, stay low.
  assign port_out  = port_oe ? {{(DATA_W-CHAN_W){1'b0}}, chan_q} : '0;

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    case (state)
      ST_IDLE:  if (accept && allowed) begin load = 1'b1; load_val = CNT_W'(T_SETUP - 1); end
      ST_SETUP: if (expired)           begin load = 1'b1; load_val = CNT_W'(T_LATCH - 1); end
      ST_LATCH: if (expired)           begin load = 1'b1; load_val = CNT_W'(T_CONV - 1);  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      chan_q <= '0;
      result <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (allowed) begin
            state  <= ST_SETUP;
            chan_q <= req_chan;
          end else begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_SETUP: if (expired) state <= ST_LATCH;
        ST_LATCH: if (expired) state <= ST_CONV;
        ST_CONV:  if (expired) state <= ST_GAP;
        ST_GAP: begin
          result <= port_in;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: bus released a full cycle before the sample edge.
  p_release_before_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> !$past(port_oe));
  // R5: done is a single-cycle pulse.
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a rejection leaves port and control line untouched.
  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (!$past(port_oe) && !$past(latch_ctl)));
  // R9: result moves only with a successful done.
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (done && !err));
  // R3: latch pulse only while the channel is driven.
  p_latch_with_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ctl |-> (port_oe && busy));
  // R8: driven channel does not change mid-sequence.
  p_chan_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_oe && $past(port_oe)) |-> $stable(port_out));
endmodule

// File: tb/adc_read_seq_tb_top.sv
module adc_read_seq_tb_top;
  localparam int T1 = 8, T2 = 6, T3 = 12;
  localparam int TT = T1 + T2 + T3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mach_old = 1'b0;
  logic [3:0] req_chan = '0;
  logic [7:0] port_in = '0;
  logic req_ready, busy, done, err, port_oe, latch_ctl;
  logic [7:0] result, port_out;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] last_res = '0;

  always #4 clk = ~clk;  // 125 MHz

  adc_read_seq #(.T_SETUP(T1), .T_LATCH(T2), .T_CONV(T3)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .mach_old(mach_old), .busy(busy), .done(done),
    .err(err), .result(result), .port_out(port_out), .port_oe(port_oe),
    .port_in(port_in), .latch_ctl(latch_ctl));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(!port_oe && !latch_ctl && !busy && !done && req_ready && result == 0,
        "R1 reset state", {port_oe, latch_ctl, busy, done, req_ready}, 5'b00001);
  endtask

  task automatic t_read(input logic [3:0] ch, input logic mo, input logic [7:0] pv,
                        input bit spam);
    int bad_s = 0, bad_l = 0, bad_c = 0, bad_b = 0;
    @(negedge clk);
    mach_old = mo; req_chan = ch; req_valid = 1'b1; port_in = pv;
    for (int n = 1; n <= TT + 2; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (spam && n >= 2 && n < TT) begin req_valid = 1'b1; req_chan = ~ch; end
      if (spam && n == TT) req_valid = 1'b0;
      if (n <= TT && (!busy || req_ready)) bad_b++;
      if (n <= T1) begin
        if (!port_oe || latch_ctl || port_out != {4'h0, ch}) bad_s++;
      end else if (n <= T1 + T2) begin
        if (!port_oe || !latch_ctl || port_out != {4'h0, ch}) bad_l++;
      end else if (n <= TT) begin
        if (!port_oe || latch_ctl) bad_c++;
      end else if (n == TT + 1) begin
        chk(!port_oe && !latch_ctl && !done, "R5 port released before sample",
            {port_oe, done}, 0);
      end else begin
        chk(done && !err && result == pv, "R5 done with sampled result",
            result, pv);
        last_res = pv;
      end
    end
    chk(bad_s == 0, "R2 setup drive/channel/fast bit", bad_s, 0);
    chk(bad_l == 0, "R3 latch window", bad_l, 0);
    chk(bad_c == 0, "R4 conversion window", bad_c, 0);
    chk(bad_b == 0, "R8 busy/ready during sequence", bad_b, 0);
    @(negedge clk);
    chk(!busy && !done && result == pv, "R8 R9 idle after done, result held",
        {busy, done}, 0);
  endtask

  task automatic t_reject(input logic [3:0] ch);
    @(negedge clk);
    mach_old = 1'b0; req_chan = ch; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && err && !port_oe && !latch_ctl && !busy,
        "R6 rejected channel flags error", {done, err, port_oe, latch_ctl}, 4'b1100);
    chk(result == last_res, "R6 result unchanged on reject", result, last_res);
    @(negedge clk);
    chk(!done && !port_oe && !busy, "R6 quiet after reject", {done, port_oe}, 0);
  endtask

  task automatic t_idle_no_valid();
    int bad = 0;
    @(negedge clk);
    req_valid = 1'b0; req_chan = 4'h7; mach_old = 1'b1;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      if (busy || port_oe || done) bad++;
    end
    chk(bad == 0, "R10 no valid keeps idle", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(4'h3, 1'b0, 8'hA5, 1'b0);       // R2..R5 on allowed channel, new machine
    t_read(4'hC, 1'b1, 8'h3C, 1'b0);       // R7: channel 12 on old machine
    t_read(4'hF, 1'b0, 8'h81, 1'b1);       // R8: requests while busy ignored
    t_read(4'h0, 1'b1, 8'h00, 1'b0);       // R7: channel 0, zero result
    foreach (gate_list[i]) t_reject(gate_list[i]);  // R6
    chk(result == 8'h00, "R9 result kept after rejections", result, 0);
    t_idle_no_valid();
    t_read(4'h5, 1'b1, 8'hFF, 1'b0);       // R7: channel 5 allowed on old machine
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [3:0] gate_list [7] = '{4'd4, 4'd5, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14};
endmodule